// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a single load or store in a 32-bit load/store core, and the value that goes back into the base register when the instruction asks for base update. It takes the base register value, picks an offset from one of three sources, adds or subtracts that offset, and then applies one of three indexing disciplines.

The three indexing disciplines differ in which value drives the access and in whether the base is rewritten. The offset sources are a zero-extended 12-bit immediate, a plain index register, or an index register passed through a barrel shifter. When the program counter serves as the base, the block substitutes the pipelined read value of the PC, which depends on the instruction-size state.

Decode presents one request per cycle with a valid strobe. The address, the new base value and the writeback enable appear registered one cycle later, qualified by a valid output.

Top module: `ls_addr_gen`

## Requirements
- R1: With `idx_mode` 0 (offset) or 3 (treated as offset), `mem_addr` equals the adjusted base and `wb_en` is 0; `wb_value` also carries the adjusted base.
- R2: With `idx_mode` 1 (pre-indexed), `mem_addr` and `wb_value` both equal the adjusted base and `wb_en` is 1.
- R3: With `idx_mode` 2 (post-indexed), `mem_addr` equals the unmodified base, `wb_value` equals the adjusted base, and `wb_en` is 1.
- R4: `off_src` selects the offset. 0 is `imm_off` zero-extended to 32 bits. 1 is `index_val` unshifted, with the shift inputs ignored. 2 is `index_val` after the shifter. 3 gives an offset of zero.
- R5: `add_sel`=1 forms base+offset and `add_sel`=0 forms base-offset, both modulo 2^32.
- R6: For `shift_amt` 1 to 31, `shift_kind` 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right.
- R7: For `shift_amt` 0, logical left leaves the value unchanged, logical right yields 0, and arithmetic right yields 32 copies of bit 31.
- R8: Rotate right with `shift_amt` 0 is a one-bit rotate through carry: the result is `{carry_in, index_val[31:1]}`.
- R9: With `base_is_pc`=1, the base is `pc_addr`+8 when `narrow_isa`=0 and `pc_addr`+4 when `narrow_isa`=1, and `base_val` is ignored.
- R10: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and the result outputs change only in that cycle.
- R11: After reset, `out_valid`, `mem_addr`, `wb_value` and `wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| pc_addr | input | 32 | Address of the current instruction |
| narrow_isa | input | 1 | 1 = 16-bit instruction state, 0 = 32-bit |
| off_src | input | 2 | Offset source select |
| imm_off | input | 12 | Unsigned immediate offset |
| index_val | input | 32 | Index register value |
| shift_kind | input | 2 | Shift type for scaled offsets |
| shift_amt | input | 5 | Shift amount |
| carry_in | input | 1 | Carry flag used by rotate-through-carry |
| add_sel | input | 1 | 1 = add offset, 0 = subtract |
| idx_mode | input | 2 | Indexing discipline |
| out_valid | output | 1 | Result valid |
| mem_addr | output | 32 | Access address |
| wb_value | output | 32 | New base register value |
| wb_en | output | 1 | Base writeback enable |

## Verification
Every result output is due exactly one clock after the cycle in which `in_valid` is sampled high. No output is due from any other cycle. The bench presents each request on a falling edge and holds `in_valid` for one cycle. It compares all four outputs on the following falling edge, one rising edge later. Idle cycles with scrambled inputs are then checked to confirm that `out_valid` drops and the results hold. A back-to-back pair confirms that each request's results land in their own cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int XLEN = 32;
    localparam int SHAMT_W = $clog2(XLEN);

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'd0,
        IDX_PRE    = 2'd1,
        IDX_POST   = 2'd2,
        IDX_ALT    = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        SRC_IMM    = 2'd0,
        SRC_REG    = 2'd1,
        SRC_SCALED = 2'd2,
        SRC_NONE   = 2'd3
    } off_src_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wb_val;
        logic            wb_en;
    } agu_result_t;

endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
    import agu_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int SA_W = SHAMT_W
) (
    input  logic [W-1:0]    val_in,
    input  logic [1:0]      kind,
    input  logic [SA_W-1:0] amt,
    input  logic            carry_in,
    output logic [W-1:0]    val_out
);

    logic [2*W-1:0] rot_dbl;
    logic           amt_zero;

    always_comb begin
        rot_dbl  = {val_in, val_in} >> amt;
        amt_zero = (amt == '0);
        unique case (shift_e'(kind))
            SH_LSL: val_out = val_in << amt;
            SH_LSR: val_out = amt_zero ? '0 : (val_in >> amt);
            SH_ASR: val_out = amt_zero ? {W{val_in[W-1]}}
                                       : W'($signed(val_in) >>> amt);
            SH_ROR: val_out = amt_zero ? {carry_in, val_in[W-1:1]}
                                       : rot_dbl[W-1:0];
            default: val_out = val_in;
        endcase
    end

endmodule

// File: rtl/agu_base_sel.sv
module agu_base_sel
    import agu_pkg::*;
#(
    parameter int W            = XLEN,
    parameter int AHEAD_WIDE   = 8,
    parameter int AHEAD_NARROW = 4
) (
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] pc_addr,
    input  logic         base_is_pc,
    input  logic         narrow_isa,
    output logic [W-1:0] eff_base
);

    localparam logic [W-1:0] INC_WIDE   = W'(AHEAD_WIDE);
    localparam logic [W-1:0] INC_NARROW = W'(AHEAD_NARROW);

    logic [W-1:0] pc_read;

    always_comb begin
        pc_read  = pc_addr + (narrow_isa ? INC_NARROW : INC_WIDE);
        eff_base = base_is_pc ? pc_read : base_val;
    end

endmodule

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IMM_W = 12
) (
    input  logic [1:0]     src,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [W-1:0]   index_val,
    input  logic [W-1:0]   scaled_val,
    output logic [W-1:0]   offset
);

    localparam int PAD_W = W - IMM_W;

    always_comb begin
        unique case (off_src_e'(src))
            SRC_IMM:    offset = {{PAD_W{1'b0}}, imm_off};
            SRC_REG:    offset = index_val;
            SRC_SCALED: offset = scaled_val;
            default:    offset = '0;
        endcase
    end

endmodule

// File: rtl/agu_index_ctrl.sv
module agu_index_ctrl
    import agu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] offset,
    input  logic         add_sel,
    input  logic [1:0]   mode,
    output logic [W-1:0] addr,
    output logic [W-1:0] wb_val,
    output logic         wb_en
);

    logic [W-1:0] adjusted;

    always_comb begin
        adjusted = add_sel ? (base + offset) : (base - offset);
        wb_val   = adjusted;
        unique case (idx_mode_e'(mode))
            IDX_PRE: begin
                addr  = adjusted;
                wb_en = 1'b1;
            end
            IDX_POST: begin
                addr  = base;
                wb_en = 1'b1;
            end
            default: begin
                addr  = adjusted;
                wb_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import agu_pkg::*;
#(
    parameter int IMM_W        = 12,
    parameter int AHEAD_WIDE   = 8,
    parameter int AHEAD_NARROW = 4,
    parameter bit HAS_SCALER   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [XLEN-1:0]    base_val,
    input  logic               base_is_pc,
    input  logic [XLEN-1:0]    pc_addr,
    input  logic               narrow_isa,
    input  logic [1:0]         off_src,
    input  logic [IMM_W-1:0]   imm_off,
    input  logic [XLEN-1:0]    index_val,
    input  logic [1:0]         shift_kind,
    input  logic [SHAMT_W-1:0] shift_amt,
    input  logic               carry_in,
    input  logic               add_sel,
    input  logic [1:0]         idx_mode,
    output logic               out_valid,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    wb_value,
    output logic               wb_en
);

    logic [XLEN-1:0] eff_base;
    logic [XLEN-1:0] scaled_val;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] comb_addr;
    logic [XLEN-1:0] comb_wb;
    logic            comb_wb_en;

    agu_result_t res_d, res_q;

    agu_base_sel #(
        .W(XLEN), .AHEAD_WIDE(AHEAD_WIDE), .AHEAD_NARROW(AHEAD_NARROW)
    ) base_sel_i (
        .base_val  (base_val),
        .pc_addr   (pc_addr),
        .base_is_pc(base_is_pc),
        .narrow_isa(narrow_isa),
        .eff_base  (eff_base)
    );

    generate
        if (HAS_SCALER) begin : g_scaler
            agu_shifter #(.W(XLEN), .SA_W(SHAMT_W)) shifter_i (
                .val_in  (index_val),
                .kind    (shift_kind),
                .amt     (shift_amt),
                .carry_in(carry_in),
                .val_out (scaled_val)
            );
        end else begin : g_no_scaler
            assign scaled_val = index_val;
        end
    endgenerate

    agu_offset_sel #(.W(XLEN), .IMM_W(IMM_W)) offset_sel_i (
        .src       (off_src),
        .imm_off   (imm_off),
        .index_val (index_val),
        .scaled_val(scaled_val),
        .offset    (offset)
    );

    agu_index_ctrl #(.W(XLEN)) index_ctrl_i (
        .base   (eff_base),
        .offset (offset),
        .add_sel(add_sel),
        .mode   (idx_mode),
        .addr   (comb_addr),
        .wb_val (comb_wb),
        .wb_en  (comb_wb_en)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.addr   = comb_addr;
            res_d.wb_val = comb_wb;
            res_d.wb_en  = comb_wb_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign mem_addr  = res_q.addr;
    assign wb_value  = res_q.wb_val;
    assign wb_en     = res_q.wb_en;

    // R1: offset-style requests never enable writeback
    p_offset_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (idx_mode == IDX_OFFSET || idx_mode == IDX_ALT) |=> !wb_en);

    // R2: pre-indexed access address equals written-back base
    p_pre_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && idx_mode == IDX_PRE |=> (mem_addr == wb_value) && wb_en);

    // R3: post-indexed access uses the incoming base unchanged
    p_post_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && idx_mode == IDX_POST && !base_is_pc
        |=> (mem_addr == $past(base_val)) && wb_en);

    // R10: a strobe yields a valid result one cycle later
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: without a strobe the results hold and valid drops
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(mem_addr) && $stable(wb_value)
                      && $stable(wb_en));

endmodule

// File: tb/ls_addr_gen_tb_top.sv
`timescale 1ns/1ps
module ls_addr_gen_tb_top;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  src;
        logic        add;
        logic [1:0]  kind;
        logic [4:0]  amt;
        logic        cin;
        logic        pc;
        logic        nar;
        logic [31:0] base;
        logic [31:0] pca;
        logic [31:0] idx;
        logic [11:0] imm;
        logic [31:0] ea;
        logic [31:0] ew;
        logic        ewe;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R1 offset imm
        '{2'd0,2'd0,1'b1,2'd0,5'd0,1'b0,1'b0,1'b0,32'h1009C,32'h0,32'h0,12'd2,32'h1009E,32'h1009E,1'b0,4'd1},
        // R2 pre imm
        '{2'd1,2'd0,1'b1,2'd0,5'd0,1'b0,1'b0,1'b0,32'h1009C,32'h0,32'h0,12'd4,32'h100A0,32'h100A0,1'b1,4'd2},
        // R3 post imm
        '{2'd2,2'd0,1'b1,2'd0,5'd0,1'b0,1'b0,1'b0,32'h100A0,32'h0,32'h0,12'd4,32'h100A0,32'h100A4,1'b1,4'd3},
        // R6 pre scaled LSL 2
        '{2'd1,2'd2,1'b1,2'd0,5'd2,1'b0,1'b0,1'b0,32'h1009C,32'h0,32'h3,12'd0,32'h100A8,32'h100A8,1'b1,4'd6},
        // R3 post scaled LSL 2
        '{2'd2,2'd2,1'b1,2'd0,5'd2,1'b0,1'b0,1'b0,32'h100A8,32'h0,32'h3,12'd0,32'h100A8,32'h100B4,1'b1,4'd3},
        // R5 subtract register
        '{2'd0,2'd1,1'b0,2'd0,5'd0,1'b0,1'b0,1'b0,32'h1009F,32'h0,32'h3,12'd0,32'h1009C,32'h1009C,1'b0,4'd5},
        // R4 source 3 gives zero
        '{2'd0,2'd3,1'b1,2'd0,5'd0,1'b0,1'b0,1'b0,32'h1000,32'h0,32'h5,12'd7,32'h1000,32'h1000,1'b0,4'd4},
        // R5 wrap
        '{2'd0,2'd0,1'b1,2'd0,5'd0,1'b0,1'b0,1'b0,32'hFFFFF001,32'h0,32'h0,12'hFFF,32'h0,32'h0,1'b0,4'd5},
        // R6 LSR 4
        '{2'd0,2'd2,1'b1,2'd1,5'd4,1'b0,1'b0,1'b0,32'h0,32'h0,32'h80000000,12'd0,32'h08000000,32'h08000000,1'b0,4'd6},
        // R6 ASR 4
        '{2'd0,2'd2,1'b1,2'd2,5'd4,1'b0,1'b0,1'b0,32'h0,32'h0,32'h80000000,12'd0,32'hF8000000,32'hF8000000,1'b0,4'd6},
        // R6 ROR 8
        '{2'd0,2'd2,1'b1,2'd3,5'd8,1'b0,1'b0,1'b0,32'h1,32'h0,32'hAB,12'd0,32'hAB000001,32'hAB000001,1'b0,4'd6},
        // R7 LSR 0 -> 0
        '{2'd0,2'd2,1'b1,2'd1,5'd0,1'b0,1'b0,1'b0,32'h40,32'h0,32'hFFFFFFFF,12'd0,32'h40,32'h40,1'b0,4'd7},
        // R7 ASR 0 negative
        '{2'd0,2'd2,1'b1,2'd2,5'd0,1'b0,1'b0,1'b0,32'h40,32'h0,32'h80000000,12'd0,32'h3F,32'h3F,1'b0,4'd7},
        // R7 ASR 0 positive
        '{2'd0,2'd2,1'b1,2'd2,5'd0,1'b0,1'b0,1'b0,32'h40,32'h0,32'h7FFFFFFF,12'd0,32'h40,32'h40,1'b0,4'd7},
        // R7 LSL 0 subtract
        '{2'd0,2'd2,1'b0,2'd0,5'd0,1'b0,1'b0,1'b0,32'h0,32'h0,32'h1234,12'd0,32'hFFFFEDCC,32'hFFFFEDCC,1'b0,4'd7},
        // R8 rotate through carry, carry 1
        '{2'd0,2'd2,1'b1,2'd3,5'd0,1'b1,1'b0,1'b0,32'h0,32'h0,32'h3,12'd0,32'h80000001,32'h80000001,1'b0,4'd8},
        // R8 rotate through carry, carry 0
        '{2'd0,2'd2,1'b1,2'd3,5'd0,1'b0,1'b0,1'b0,32'h10,32'h0,32'h3,12'd0,32'h11,32'h11,1'b0,4'd8},
        // R9 PC wide state
        '{2'd0,2'd0,1'b1,2'd0,5'd0,1'b0,1'b1,1'b0,32'hDEAD0000,32'h8074,32'h0,12'd12,32'h8088,32'h8088,1'b0,4'd9},
        // R9 PC narrow state, post
        '{2'd2,2'd0,1'b1,2'd0,5'd0,1'b0,1'b1,1'b1,32'hDEAD0000,32'h8000,32'h0,12'd0,32'h8004,32'h8004,1'b1,4'd9},
        // R1 mode 3 acts as offset
        '{2'd3,2'd0,1'b1,2'd0,5'd0,1'b0,1'b0,1'b0,32'h100,32'h0,32'h0,12'd8,32'h108,32'h108,1'b0,4'd1},
        // R4 plain register ignores shift inputs
        '{2'd0,2'd1,1'b1,2'd0,5'd4,1'b0,1'b0,1'b0,32'h100,32'h0,32'h10,12'd0,32'h110,32'h110,1'b0,4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic        base_is_pc = 1'b0;
    logic [31:0] pc_addr = '0;
    logic        narrow_isa = 1'b0;
    logic [1:0]  off_src = '0;
    logic [11:0] imm_off = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic        carry_in = 1'b0;
    logic        add_sel = 1'b1;
    logic [1:0]  idx_mode = '0;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [31:0] wb_value;
    logic        wb_en;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    ls_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .base_val(base_val), .base_is_pc(base_is_pc), .pc_addr(pc_addr),
        .narrow_isa(narrow_isa), .off_src(off_src), .imm_off(imm_off),
        .index_val(index_val), .shift_kind(shift_kind), .shift_amt(shift_amt),
        .carry_in(carry_in), .add_sel(add_sel), .idx_mode(idx_mode),
        .out_valid(out_valid), .mem_addr(mem_addr), .wb_value(wb_value),
        .wb_en(wb_en)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        idx_mode   = v.mode;
        off_src    = v.src;
        add_sel    = v.add;
        shift_kind = v.kind;
        shift_amt  = v.amt;
        carry_in   = v.cin;
        base_is_pc = v.pc;
        narrow_isa = v.nar;
        base_val   = v.base;
        pc_addr    = v.pca;
        index_val  = v.idx;
        imm_off    = v.imm;
    endtask

    task automatic check_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        chk(tag, "mem_addr", mem_addr, v.ea);
        chk(tag, "wb_value", wb_value, v.ew);
        chk(tag, "wb_en", {31'd0, wb_en}, {31'd0, v.ewe});
        chk("R10", "out_valid", {31'd0, out_valid}, 32'd1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R11", "mem_addr", mem_addr, 32'd0);
        chk("R11", "wb_value", wb_value, 32'd0);
        chk("R11", "wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_vec(VECS[i]);
            @(negedge clk);
        end

        // R10: idle cycles with scrambled inputs hold the last result
        drive(VECS[1]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(VECS[1]);
        base_val  = 32'h5555AAAA;
        idx_mode  = 2'd2;
        imm_off   = 12'h123;
        @(negedge clk);
        chk("R10", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10", "idle mem_addr", mem_addr, VECS[1].ea);
        chk("R10", "idle wb_value", wb_value, VECS[1].ew);
        chk("R10", "idle wb_en", {31'd0, wb_en}, 32'd1);
        @(negedge clk);
        chk("R10", "idle2 mem_addr", mem_addr, VECS[1].ea);

        // R10: back-to-back strobes land one per cycle (R2 then R3 chain)
        drive(VECS[3]);
        in_valid = 1'b1;
        @(negedge clk);
        check_vec(VECS[3]);
        drive(VECS[4]);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(VECS[4]);
        @(negedge clk);
        chk("R10", "after pair out_valid", {31'd0, out_valid}, 32'd0);

        // R11: reset mid-run clears results
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "reset mem_addr", mem_addr, 32'd0);
        chk("R11", "reset wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule